// File: doc/BRIEF.md
# I2C Master Command and Byte Engine

This block is the bus-facing core of an I2C master. Software drives it through a small register window. A control register enables the core and issues bus conditions: START, repeated START or STOP. Bytes written to the data register queue up in a transmit FIFO. The core shifts each byte out MSB first on SCL/SDA, then samples the acknowledge slot and keeps the outcome in the control register.

Completion of any condition or byte raises a session-done flag. The interrupt status flags clear when software writes 1 to them. A NAK from the slave empties the FIFO straight away, so queued data never reaches a device that has refused. SCL timing comes from one divider register that counts core clocks per half SCL period. The lines are open-drain: an output bit of 0 pulls the line low. A returned-to-idle command leaves the lines exactly where they are.

Register map (`reg_addr`): 0 control, 1 divider, 2 transmit data (write only), 3 interrupt status, 4 FIFO control.

Top module: `i2cm_core`

## Requirements
- R1: After reset, SCL and SDA are released (both outputs 1), and the control and interrupt status registers read 0.
- R2: The control register holds the enable in bit 0 and the command in bits [2:1]. The command codes are 0 for no action, 1 for start or restart, and 2 for stop. With code 1, bit 3 = 0 makes a START from an idle bus and bit 3 = 1 makes a repeated START. A command runs only if the same write sets bit 0.
- R3: Each byte from the FIFO goes out MSB first, with SDA changing only while SCL is low, and is followed by one acknowledge clock. Bytes leave in the order they were written.
- R4: After a byte, control bit 3 reads 1 if the slave sent NAK (SDA high in the acknowledge slot) and 0 if it sent ACK.
- R5: Interrupt status bit 3 (session done) is set when a START, repeated START, STOP or byte completes.
- R6: Interrupt status bit 7 reads 1 from the moment a command is accepted until its bus condition finishes. A write of a nonzero command while a command or byte is in progress is ignored as a whole, and the control register keeps its previous value.
- R7: On a NAK the remaining FIFO bytes are discarded and never sent, and interrupt status bits 0 (NAK) and 1 (TX empty) are set. Bit 1 is also set when a byte completes and the FIFO is empty.
- R8: In the FIFO control register (address 4), bit 6 enables the FIFO and gates data writes. Writing bit 7 as 1 discards all queued bytes. Bit 7 always reads back 0. The FIFO holds 64 bytes by default.
- R9: Writing 1 to an interrupt status bit clears it, and writing 0 leaves it unchanged. Bits 2, 4, 5 and 6 read 0.
- R10: Every bus step lasts the divider value in core clocks. The SCL high time of a data or acknowledge clock equals the divider.
- R11: While no command or byte is running, SCL and SDA hold their last levels. After a START, SCL stays low until the next command or byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, registered, valid one cycle after `reg_addr` |
| scl_o | output | 1 | SCL drive, 0 pulls the line low |
| sda_o | output | 1 | SDA drive, 0 pulls the line low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
A wrong step counter or shift register shows up at once on the pins. The monitor decodes the wrong bit, sees a spurious START or STOP, or measures the wrong high time, all within the same byte. A missed FIFO flush appears as an extra byte on the bus about one byte time after the NAK, before the STOP the bench expects next. A stale busy or acknowledge state is seen on the next register read: a swallowed or duplicated bus condition, or a control bit 3 that does not match the slave's answer.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_STOP    = 3'd3,
    OP_BYTE    = 3'd4
  } op_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_DIV  = 3'd1;
  localparam logic [2:0] RA_DATA = 3'd2;
  localparam logic [2:0] RA_ISR  = 3'd3;
  localparam logic [2:0] RA_FCTL = 3'd4;

  localparam logic [1:0] CMD_IDLE  = 2'd0;
  localparam logic [1:0] CMD_START = 2'd1;
  localparam logic [1:0] CMD_STOP  = 2'd2;
endpackage

// File: rtl/i2cm_txfifo.sv
module i2cm_txfifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic          full, push_ok, pop_ok;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/i2cm_bitgen.sv
module i2cm_bitgen
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  op_e              op_in,
  input  logic [7:0]       byte_in,
  input  logic [DIV_W-1:0] half_div,
  input  logic             sda_i,
  output logic             busy,
  output logic             done,
  output logic             nak,
  output op_e              op_q,
  output logic             scl_o,
  output logic             sda_o
);
  logic [7:0]       shreg;
  logic [4:0]       step;
  logic [DIV_W-1:0] cnt, reload;
  logic [2:0]       cur, nxt, first;

  // {last step, scl, sda} for one step of a sequence
  function automatic logic [2:0] lines(op_e op, logic [4:0] s, logic [7:0] b);
    case (op)
      OP_START:   return {s == 5'd1, s == 5'd0, 1'b0};
      OP_RESTART: return {s == 5'd3, (s == 5'd1) || (s == 5'd2), s < 5'd2};
      OP_STOP:    return {s == 5'd2, s != 5'd0, s == 5'd2};
      OP_BYTE: begin
        if (s < 5'd16) return {1'b0, s[0], b[3'd7 - s[3:1]]};
        else           return {s == 5'd17, s[0], 1'b1};
      end
      default:    return 3'b011;
    endcase
  endfunction

  assign reload = (half_div == '0) ? '0 : half_div - 1'b1;
  assign cur    = lines(op_q, step, shreg);
  assign nxt    = lines(op_q, 5'(step + 5'd1), shreg);
  assign first  = lines(op_in, 5'd0, byte_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      nak   <= 1'b0;
      op_q  <= OP_NONE;
      shreg <= '0;
      step  <= '0;
      cnt   <= '0;
      scl_o <= 1'b1;
      sda_o <= 1'b1;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        op_q  <= op_in;
        shreg <= byte_in;
        step  <= '0;
        cnt   <= reload;
        busy  <= 1'b1;
        scl_o <= first[1];
        sda_o <= first[0];
      end else if (busy) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (cur[2]) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (op_q == OP_BYTE) begin
            nak   <= sda_i;
            scl_o <= 1'b0;
          end
        end else begin
          step  <= 5'(step + 5'd1);
          cnt   <= reload;
          scl_o <= nxt[1];
          sda_o <= nxt[0];
        end
      end
    end
  end

  assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && op_q == OP_BYTE && !$stable(sda_o)) |-> !scl_o);
  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/i2cm_core.sv
module i2cm_core
  import i2cm_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 64,
  parameter int DIV_RESET  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i
);
  logic             en_q, ack_q, fifo_en_q, cmd_busy_q;
  logic [1:0]       cmd_q;
  logic [DIV_W-1:0] div_q;
  logic             nak_f, txe_f, sd_f;

  logic       bg_busy, bg_done, bg_nak, go, accept, launch;
  op_e        bg_op, go_op;
  logic [7:0] fifo_dout;
  logic       fifo_empty, fifo_flush, fifo_push;
  logic       wr_ctrl, ctrl_drop, byte_end, set_nak, set_txe;
  logic [1:0] wcmd;

  assign wr_ctrl   = reg_we && (reg_addr == RA_CTRL);
  assign wcmd      = reg_wdata[2:1];
  assign ctrl_drop = wr_ctrl && (wcmd != CMD_IDLE) && bg_busy;
  assign accept    = wr_ctrl && !bg_busy && reg_wdata[0] &&
                     (wcmd == CMD_START || wcmd == CMD_STOP);
  assign launch    = !bg_busy && !bg_done && !accept && en_q && fifo_en_q && !fifo_empty;
  assign go        = accept || launch;

  always_comb begin
    if (!accept)               go_op = OP_BYTE;
    else if (wcmd == CMD_STOP) go_op = OP_STOP;
    else if (reg_wdata[3])     go_op = OP_RESTART;
    else                       go_op = OP_START;
  end

  assign byte_end   = bg_done && (bg_op == OP_BYTE);
  assign set_nak    = byte_end && bg_nak;
  assign set_txe    = byte_end && (bg_nak || fifo_empty);
  assign fifo_flush = set_nak || (reg_we && reg_addr == RA_FCTL && reg_wdata[7]);
  assign fifo_push  = reg_we && (reg_addr == RA_DATA) && fifo_en_q;

  i2cm_txfifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst(rst), .push(fifo_push), .din(reg_wdata), .pop(launch),
    .flush(fifo_flush), .dout(fifo_dout), .empty(fifo_empty)
  );

  i2cm_bitgen #(.DIV_W(DIV_W)) u_bitgen (
    .clk(clk), .rst(rst), .go(go), .op_in(go_op), .byte_in(fifo_dout),
    .half_div(div_q), .sda_i(sda_i), .busy(bg_busy), .done(bg_done),
    .nak(bg_nak), .op_q(bg_op), .scl_o(scl_o), .sda_o(sda_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      cmd_q      <= CMD_IDLE;
      ack_q      <= 1'b0;
      cmd_busy_q <= 1'b0;
      fifo_en_q  <= 1'b0;
      div_q      <= DIV_W'(DIV_RESET);
    end else begin
      if (wr_ctrl && !ctrl_drop) begin
        en_q  <= reg_wdata[0];
        cmd_q <= wcmd;
        ack_q <= reg_wdata[3];
      end
      if (byte_end) ack_q <= bg_nak;
      if (accept) cmd_busy_q <= 1'b1;
      else if (bg_done && bg_op != OP_BYTE) cmd_busy_q <= 1'b0;
      if (reg_we && reg_addr == RA_DIV)  div_q     <= DIV_W'(reg_wdata);
      if (reg_we && reg_addr == RA_FCTL) fifo_en_q <= reg_wdata[6];
    end
  end

  // interrupt flags: a set in the same cycle beats a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      nak_f <= 1'b0;
      txe_f <= 1'b0;
      sd_f  <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RA_ISR) begin
        nak_f <= (nak_f && !reg_wdata[0]) || set_nak;
        txe_f <= (txe_f && !reg_wdata[1]) || set_txe;
        sd_f  <= (sd_f  && !reg_wdata[3]) || bg_done;
      end else begin
        nak_f <= nak_f || set_nak;
        txe_f <= txe_f || set_txe;
        sd_f  <= sd_f  || bg_done;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL: reg_rdata <= {4'b0, ack_q, cmd_q, en_q};
        RA_DIV:  reg_rdata <= 8'(div_q);
        RA_ISR:  reg_rdata <= {cmd_busy_q, 3'b0, sd_f, 1'b0, txe_f, nak_f};
        RA_FCTL: reg_rdata <= {1'b0, fifo_en_q, 6'b0};
        default: reg_rdata <= '0;
      endcase
    end
  end

  assert_drop_keeps_ctrl_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_drop |=> $stable({cmd_q, en_q}));
  assert_cmd_busy_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_busy_q |-> (bg_busy || bg_done));
  assert_nak_flushes_R7: assert property (@(posedge clk) disable iff (rst)
    set_nak |=> fifo_empty);
  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (!bg_busy && !go) |=> ($stable(scl_o) && $stable(sda_o)));
endmodule

// File: tb/sim_i2cm_core.sv
module sim_i2cm_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       scl_o, sda_o;
  logic       sl_sda = 1'b1;
  logic       sl_nak = 1'b0;
  logic       sda_line;

  assign sda_line = sda_o & sl_sda;

  i2cm_core u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_line)
  );

  always #5 clk = ~clk;

  localparam int EV_START = 256, EV_RESTART = 512, EV_STOP = 768, EV_BYTE = 1024;

  int  tests = 0, fails = 0;
  int  exp_q[$];
  bit  finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor side: pop and compare each observed bus event
  task automatic got_ev(input int e);
    if (exp_q.size() == 0) chk("R3 unexpected bus event", e, -1);
    else chk("R2/R3/R7 bus event order", e, exp_q.pop_front());
  endtask

  // slave and monitor, sampled away from the active edge
  logic pscl = 1'b1, psda = 1'b1;
  int   hcnt = 0, last_high = 0, bitcnt = 0;
  logic [7:0] sh = '0;
  bit   in_x = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (scl_o && pscl && psda && !sda_line) begin
        got_ev(in_x ? EV_RESTART : EV_START);
        in_x = 1; bitcnt = 0;
      end else if (scl_o && pscl && !psda && sda_line) begin
        got_ev(EV_STOP);
        in_x = 0; bitcnt = 0;
      end else if (scl_o && !pscl) begin
        if (bitcnt < 8) begin sh = {sh[6:0], sda_line}; bitcnt++; end
        else if (bitcnt == 8) bitcnt = 9;
      end else if (!scl_o && pscl) begin
        last_high = hcnt;
        if (bitcnt == 8) begin got_ev(EV_BYTE + int'(sh)); sl_sda = sl_nak; end
        else if (bitcnt == 9) begin sl_sda = 1'b1; bitcnt = 0; end
      end
      if (scl_o) hcnt++; else hcnt = 0;
      pscl = scl_o;
      psda = sda_line;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic poll(input logic [7:0] m, input string req);
    logic [7:0] v;
    bit hit = 0;
    for (int i = 0; i < 4000 && !hit; i++) begin
      rd(3'd3, v);
      if ((v & m) != 0) hit = 1;
    end
    chk(req, int'(hit), 1);
  endtask

  logic [7:0] v;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    rd(3'd0, v); chk("R1 ctrl after reset", v, 8'h00);
    rd(3'd3, v); chk("R1 isr after reset", v, 8'h00);
    chk("R1 lines released", {scl_o, sda_o}, 2'b11);
    wr(3'd1, 8'd4);
    wr(3'd4, 8'h40);

    // R2 START, R6 ignored STOP while busy
    exp_q.push_back(EV_START);
    wr(3'd0, 8'h03);
    wr(3'd0, 8'h05);
    rd(3'd3, v); chk("R6 command busy while START runs", v[7], 1);
    poll(8'h08, "R5 session done after START");
    rd(3'd3, v); chk("R5 R6 isr after START", v, 8'h08);
    rd(3'd0, v); chk("R6 dropped write kept ctrl", v, 8'h03);
    wr(3'd0, 8'h01);
    wr(3'd3, 8'hFF);
    repeat (40) @(negedge clk);
    chk("R11 SCL held low while idle", scl_o, 0);

    // R3 R4 two bytes acknowledged
    sl_nak = 1'b0;
    exp_q.push_back(EV_BYTE + 8'hA5);
    exp_q.push_back(EV_BYTE + 8'h3C);
    wr(3'd2, 8'hA5);
    wr(3'd2, 8'h3C);
    poll(8'h02, "R7 TX empty after last byte");
    rd(3'd0, v); chk("R4 ACK reads 0", v[3], 0);
    rd(3'd3, v); chk("R5 R7 isr after bytes", v, 8'h0A);
    chk("R10 SCL high time div=4", last_high, 4);
    wr(3'd3, 8'h08);
    rd(3'd3, v); chk("R9 clear only session done", v, 8'h02);
    wr(3'd3, 8'h02);
    rd(3'd3, v); chk("R9 clear TX empty", v, 8'h00);

    // R2 repeated START
    exp_q.push_back(EV_RESTART);
    wr(3'd0, 8'h0B);
    poll(8'h08, "R5 session done after RESTART");
    wr(3'd0, 8'h01);
    wr(3'd3, 8'hFF);

    // R7 NAK flushes the rest of the FIFO
    wr(3'd1, 8'd6);
    sl_nak = 1'b1;
    exp_q.push_back(EV_BYTE + 8'h91);
    wr(3'd2, 8'h91);
    wr(3'd2, 8'h22);
    wr(3'd2, 8'h33);
    poll(8'h01, "R7 NAK flag set");
    rd(3'd0, v); chk("R4 NAK reads 1", v[3], 1);
    rd(3'd3, v); chk("R7 NAK and TX empty", v & 8'h03, 8'h03);
    chk("R10 SCL high time div=6", last_high, 6);
    sl_nak = 1'b0;
    wr(3'd3, 8'hFF);
    repeat (300) @(negedge clk);
    exp_q.push_back(EV_STOP);
    wr(3'd0, 8'h05);
    poll(8'h08, "R5 session done after STOP");
    wr(3'd0, 8'h01);
    wr(3'd3, 8'hFF);
    chk("R2 bus free after STOP", {scl_o, sda_o}, 2'b11);

    // R8 flush discards queued bytes
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h55);
    wr(3'd2, 8'h66);
    wr(3'd4, 8'hC0);
    rd(3'd4, v); chk("R8 flush bit reads 0", v, 8'h40);
    wr(3'd0, 8'h01);
    repeat (300) @(negedge clk);
    exp_q.push_back(EV_START);
    wr(3'd0, 8'h03);
    poll(8'h08, "R5 START after flush");
    wr(3'd0, 8'h01);
    wr(3'd3, 8'hFF);
    exp_q.push_back(EV_BYTE + 8'h77);
    wr(3'd2, 8'h77);
    poll(8'h08, "R5 byte after flush");
    wr(3'd3, 8'hFF);
    exp_q.push_back(EV_STOP);
    wr(3'd0, 8'h05);
    poll(8'h08, "R5 final STOP");
    wr(3'd0, 8'h01);
    repeat (20) @(negedge clk);
    chk("R3 all expected events seen", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule